// File: doc/BRIEF.md
# Serial EEPROM Command Slave

This block is a small byte-wide non-volatile memory model that answers on a four-wire serial bus in clock mode 0. A host pulls chip select low, clocks in an 8-bit instruction, and depending on that instruction either an address byte followed by data, or status bytes. The block keeps a write-enable latch, two block-protect bits and an internal register array of up to 512 bytes. A write or status write is buffered while chip select is low and committed when chip select rises. A self-timed write cycle, counted in system clocks, then runs. While it runs the status register reports busy, and every instruction except a status read is refused.

All serial pins are oversampled by the system clock `clk` through a synchronizer, so the serial clock must be several times slower than `clk`. The serial interface has no back-pressure: every byte the host clocks is consumed, and read data is always ready by the next serial clock edge. There is therefore no valid/ready pair, and all pins are plain.

Top module: `eeprom_spi_slave`

## Requirements
- R1: Bits move most significant first. A transaction starts when spi_cs_n falls. MOSI is taken on the rising spi_sck edge and MISO changes after the falling edge. spi_miso is 0 while spi_cs_n is high and throughout any byte that carries no read data.
- R2: The upper nibble of an instruction byte must be 0000, and bit 3 is ignored except in memory commands. The low three bits are: 110 set enable, 100 clear enable, 101 read status, 001 write status, 011 read memory, 010 write memory. Any other byte is ignored until chip select rises.
- R3: The write-enable latch is 0 after reset. The set-enable instruction sets it only while wp_n is high. The clear-enable instruction clears it whatever the level of wp_n.
- R4: When idle, status reads as {4'b0000, bp[1], bp[0], enable, 1'b0}. A status read returns a freshly sampled status byte for every byte clocked while chip select stays low.
- R5: During a self-timed write cycle the status reads 8'hFF. Any instruction other than a status read is ignored, and a memory read returns only zeros.
- R6: A memory read uses address {instruction bit 3, address byte}. It returns consecutive bytes for as long as chip select stays low, and the address wraps from the top of the array to 0.
- R7: A memory write buffers up to PAGE data bytes at consecutive addresses, wrapping at the top of the array. Bytes beyond PAGE are discarded. The write commits at the rise of chip select only if the enable latch is set, at least one data byte was received and no partial byte is pending.
- R8: Block-protect 00 protects nothing, 01 protects the upper quarter, 10 the upper half and 11 the whole array. Bytes aimed at a protected address are dropped, and the other bytes of the same write still land.
- R9: A status write takes bits 3:2 of its first data byte as the new block-protect bits and ignores all other bits. It commits under the same rules as R7, and protection never blocks it.
- R10: A committed write keeps the block busy for max(WR_CYCLES, PAGE) clocks. The enable latch is 0 when the cycle ends.
- R11: After reset the array reads all zeros and block-protect is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Write-protect pin, high allows the set-enable instruction |
| spi_miso | output | 1 | Serial data to host |

## Verification
The bench builds the block with a 512-byte array, an 8-byte page, two synchronizer stages and WR_CYCLES set to 600. The long write cycle keeps the block busy across two full status bytes and a complete refused read, so the busy response and the refusal can both be observed in one window. The short page lets a 10-byte write show the discarded tail. The 9-bit address puts the top-of-array wrap and the upper-quarter and upper-half protection limits at addresses the bench writes across.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_WDATA, ST_SRD, ST_SWR, ST_SKIP
  } cmd_st_e;

  localparam logic [2:0] OPC_SETEN  = 3'b110;
  localparam logic [2:0] OPC_CLREN  = 3'b100;
  localparam logic [2:0] OPC_RDSTAT = 3'b101;
  localparam logic [2:0] OPC_WRSTAT = 3'b001;
  localparam logic [2:0] OPC_RDMEM  = 3'b011;
  localparam logic [2:0] OPC_WRMEM  = 3'b010;

  function automatic logic in_protected(input logic [1:0] bp,
                                        input int unsigned addr,
                                        input int unsigned depth);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return addr >= depth - depth / 4;
      2'b10:   return addr >= depth / 2;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  input  logic wp_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic mosi_s,
  output logic wp_hi
);
  // pin vector order {wp_n, cs_n, mosi, sck}
  localparam logic [3:0] PINS_RST = 4'b0100;

  logic [3:0] stage [STAGES];
  logic [1:0] prev;   // {cs_n, sck}
  logic [3:0] s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= PINS_RST;
      prev <= 2'b10;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stage[i] <= stage[i-1];
      stage[0] <= {wp_n_i, cs_n_i, mosi_i, sck_i};
      prev     <= {stage[STAGES-1][2], stage[STAGES-1][0]};
    end
  end

  assign s        = stage[STAGES-1];
  assign sck_rise = s[0] & ~prev[0];
  assign sck_fall = ~s[0] & prev[0];
  assign cs_fall  = ~s[2] & prev[1];
  assign cs_rise  = s[2] & ~prev[1];
  assign cs_low   = ~s[2];
  assign mosi_s   = s[1];
  assign wp_hi    = s[3];

  a_r1_cs_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !cs_rise);
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int AW        = 9,
  parameter int PAGE      = 8,
  parameter int WR_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          cs_low,
  input  logic          mosi_s,
  input  logic          wp_hi,
  output logic          miso,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);
  localparam int DEPTH    = 1 << AW;
  localparam int BUSY_LEN = (WR_CYCLES > PAGE) ? WR_CYCLES : PAGE;
  localparam int BW       = $clog2(BUSY_LEN + 1);
  localparam int PW       = $clog2(PAGE + 1);
  localparam int IW       = (PAGE > 1) ? $clog2(PAGE) : 1;

  cmd_st_e       st;
  logic [2:0]    bitcnt;
  logic [6:0]    shreg;
  logic [7:0]    nbyte;
  logic          byte_done;
  logic          a8, rd_op;
  logic [AW-1:0] ptr, pstart;
  logic [7:0]    tx;
  logic          miso_q;
  logic          wel;
  logic [1:0]    bp, sr_new;
  logic          sr_got;
  logic [BW-1:0] busy_cnt;
  logic          busy;
  logic          cmt_mem;
  logic [PW-1:0] pcount, cidx;
  logic [7:0]    pbuf [PAGE];
  logic [7:0]    status;
  logic [8:0]    full_addr;

  assign nbyte     = {shreg, mosi_s};
  assign byte_done = sck_rise & cs_low & (bitcnt == 3'd7);
  assign busy      = busy_cnt != '0;
  assign status    = busy ? 8'hFF : {4'b0000, bp, wel, 1'b0};
  assign full_addr = {a8, nbyte};
  assign mem_raddr = (st == ST_ADDR) ? full_addr[AW-1:0] : ptr;

  assign mem_waddr = pstart + AW'(cidx);
  assign mem_wdata = pbuf[cidx[IW-1:0]];
  assign mem_we    = busy && cmt_mem && (cidx < pcount) &&
                     !in_protected(bp, int'(mem_waddr), DEPTH);
  assign miso      = miso_q;

  always_ff @(posedge clk) begin
    if (byte_done && st == ST_WDATA && pcount < PW'(PAGE))
      pbuf[pcount[IW-1:0]] <= nbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; a8 <= 1'b0; rd_op <= 1'b0;
      ptr <= '0; pstart <= '0; tx <= '0; miso_q <= 1'b0; wel <= 1'b0;
      bp <= '0; sr_new <= '0; sr_got <= 1'b0; busy_cnt <= '0;
      cmt_mem <= 1'b0; pcount <= '0; cidx <= '0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (busy_cnt == BW'(1)) wel <= 1'b0;
        if (cmt_mem && cidx < pcount) cidx <= cidx + 1'b1;
      end

      if (cs_fall) begin
        st     <= ST_OPC;
        bitcnt <= '0;
      end else if (cs_rise) begin
        if (!busy && wel && bitcnt == 3'd0) begin
          if (st == ST_WDATA && pcount != '0) begin
            busy_cnt <= BW'(BUSY_LEN);
            cmt_mem  <= 1'b1;
            cidx     <= '0;
          end else if (st == ST_SWR && sr_got) begin
            bp       <= sr_new;
            busy_cnt <= BW'(BUSY_LEN);
            cmt_mem  <= 1'b0;
          end
        end
        st <= ST_IDLE;
      end else if (sck_rise && cs_low) begin
        bitcnt <= bitcnt + 1'b1;
        shreg  <= {shreg[5:0], mosi_s};
        if (bitcnt == 3'd7) begin
          case (st)
            ST_OPC: begin
              if (nbyte[7:4] != 4'h0) begin
                st <= ST_SKIP;
              end else if (nbyte[2:0] == OPC_RDSTAT) begin
                tx <= status;
                st <= ST_SRD;
              end else if (busy) begin
                st <= ST_SKIP;
              end else begin
                case (nbyte[2:0])
                  OPC_SETEN:  begin if (wp_hi) wel <= 1'b1; st <= ST_SKIP; end
                  OPC_CLREN:  begin wel <= 1'b0; st <= ST_SKIP; end
                  OPC_WRSTAT: begin sr_got <= 1'b0; st <= ST_SWR; end
                  OPC_RDMEM:  begin a8 <= nbyte[3]; rd_op <= 1'b1; st <= ST_ADDR; end
                  OPC_WRMEM:  begin a8 <= nbyte[3]; rd_op <= 1'b0; st <= ST_ADDR; end
                  default:    st <= ST_SKIP;
                endcase
              end
            end
            ST_ADDR: begin
              if (rd_op) begin
                tx  <= mem_rdata;
                ptr <= mem_raddr + 1'b1;
                st  <= ST_RDATA;
              end else begin
                pstart <= mem_raddr;
                pcount <= '0;
                st     <= ST_WDATA;
              end
            end
            ST_RDATA: begin
              tx  <= mem_rdata;
              ptr <= ptr + 1'b1;
            end
            ST_SRD: tx <= status;
            ST_WDATA: if (pcount < PW'(PAGE)) pcount <= pcount + 1'b1;
            ST_SWR: begin
              if (!sr_got) begin
                sr_new <= nbyte[3:2];
                sr_got <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end

      if (cs_fall || cs_rise)
        miso_q <= 1'b0;
      else if (sck_fall && cs_low)
        miso_q <= (st == ST_RDATA || st == ST_SRD) ? tx[~bitcnt] : 1'b0;
    end
  end

  // R3: the enable latch can only have been set while wp was high
  a_r3_enable_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wp_hi));
  // R5: no enable change from an instruction decoded in the write cycle
  a_r5_no_enable_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(busy));
  // R7: a write cycle only starts on the rise of chip select
  a_r7_commit_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  // R9: block-protect only moves together with the start of a write cycle
  a_r9_bp_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp) |-> $rose(busy));
  // R10: enable latch is down once the write cycle ends
  a_r10_enable_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  // R1: output quiet while deselected
  a_r1_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low && !$past(cs_low)) |-> !miso);
  // R8: array never written outside a write cycle
  a_r8_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cmt_mem && !cs_low));
endmodule

// File: rtl/eeprom_spi_slave.sv
module eeprom_spi_slave #(
  parameter int AW          = 9,
  parameter int PAGE        = 8,
  parameter int WR_CYCLES   = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_low, mosi_s, wp_hi;
  logic          mem_we;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [7:0]    mem_rdata, mem_wdata;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .wp_n_i(wp_n), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .cs_low(cs_low), .mosi_s(mosi_s), .wp_hi(wp_hi)
  );

  eeprom_cmd_ctrl #(.AW(AW), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_low(cs_low),
    .mosi_s(mosi_s), .wp_hi(wp_hi), .miso(spi_miso),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  eeprom_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: tb/eeprom_spi_slave_test.sv
`timescale 1ns/1ps
module eeprom_spi_slave_test;
  localparam int AW = 9, PAGE = 8, WRC = 600, DEPTH = 512;
  localparam int H = 8;            // clk cycles per half serial clock
  localparam int BUSY = (WRC > PAGE) ? WRC : PAGE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b0;
  logic miso;
  always #5 clk = ~clk;

  eeprom_spi_slave #(.AW(AW), .PAGE(PAGE), .WR_CYCLES(WRC), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .wp_n(wp_n), .spi_miso(miso)
  );

  int vecs = 0, errs = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference
  logic [7:0] m_mem [DEPTH];
  logic       m_wel = 1'b0;
  logic [1:0] m_bp  = 2'b00;
  int         busy_end = 0;

  function automatic bit m_busy();
    return cyc < busy_end;
  endfunction
  function automatic logic [7:0] m_status();
    return m_busy() ? 8'hFF : {4'b0000, m_bp, m_wel, 1'b0};
  endfunction
  function automatic bit m_prot(int a);
    case (m_bp)
      2'b00: return 0;
      2'b01: return a >= DEPTH - DEPTH / 4;
      2'b10: return a >= DEPTH / 2;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %02h expected %02h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      hw(H);
      q[i] = miso;
      sck = 1'b1;
      hw(H);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    hw(H);
  endtask

  task automatic desel();
    hw(H);
    cs_n = 1'b1;
  endtask

  task automatic gap();
    hw(4 * H);
  endtask

  task automatic commit();
    busy_end = cyc + BUSY + 4;
    m_wel = 1'b0;
  endtask

  task automatic cmd(logic [7:0] op, string req);
    logic [7:0] q;
    sel();
    xfer(op, q);
    chk(req, q, 8'h00);
    if (!m_busy() && op[7:4] == 4'h0) begin
      if (op[2:0] == 3'b110 && wp_n) m_wel = 1'b1;
      if (op[2:0] == 3'b100) m_wel = 1'b0;
    end
    desel(); gap();
  endtask

  task automatic rdsr(int n, string req);
    logic [7:0] q;
    logic [7:0] e;
    sel();
    e = m_status();
    xfer(8'h05, q);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, q);
      chk(req, q, e);
      e = m_status();
    end
    desel(); gap();
  endtask

  task automatic rdmem(int addr, int n, string req);
    logic [7:0] q;
    bit b;
    sel();
    b = m_busy();
    xfer({4'h0, addr[8], 3'b011}, q);
    xfer(addr[7:0], q);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, q);
      chk(req, q, b ? 8'h00 : m_mem[(addr + i) % DEPTH]);
    end
    desel(); gap();
  endtask

  task automatic wrmem(int addr, int n, logic [7:0] base, int extra_bits);
    logic [7:0] q;
    bit ok;
    sel();
    xfer({4'h0, addr[8], 3'b010}, q);
    xfer(addr[7:0], q);
    for (int i = 0; i < n; i++) xfer(base + 8'(i), q);
    for (int i = 0; i < extra_bits; i++) begin
      mosi = 1'b1; hw(H); sck = 1'b1; hw(H); sck = 1'b0;
    end
    ok = !m_busy() && m_wel && n > 0 && extra_bits == 0;
    desel();
    if (ok) begin
      for (int i = 0; i < n && i < PAGE; i++)
        if (!m_prot((addr + i) % DEPTH)) m_mem[(addr + i) % DEPTH] = base + 8'(i);
      commit();
    end
    gap();
  endtask

  task automatic wrsr(logic [7:0] v);
    logic [7:0] q;
    bit ok;
    sel();
    xfer(8'h01, q);
    xfer(v, q);
    ok = !m_busy() && m_wel;
    desel();
    if (ok) begin
      m_bp = v[3:2];
      commit();
    end
    gap();
  endtask

  task automatic settle();
    hw(BUSY + 200);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
    hw(5);
    rst_n = 1'b1;
    hw(5);
    rdsr(1, "R11 reset status");
    rdmem(9'h1F0, 2, "R11 reset array");
    // R3: enable refused with wp low
    wp_n = 1'b0; cmd(8'h06, "R3 opcode echo"); rdsr(1, "R3 wp low refuses enable");
    // R2: bit 3 is don't care for set-enable
    wp_n = 1'b1; cmd(8'h0E, "R2 opcode echo"); rdsr(2, "R2 R4 enable with bit3 set");
    // R3: clear works with wp low
    wp_n = 1'b0; cmd(8'h04, "R3 opcode echo"); rdsr(1, "R3 clear ignores wp");
    // R2: non-zero upper nibble ignored
    wp_n = 1'b1; cmd(8'h16, "R2 opcode echo"); rdsr(1, "R2 bad upper nibble ignored");
    // R7: write without enable dropped
    wrmem(9'h1FE, 3, 8'hA5, 0);
    rdsr(1, "R7 no commit without enable");
    rdmem(9'h1FE, 3, "R7 unenabled write dropped");
    // R5 R6 R10: wrapped write, busy window
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h1FE, 3, 8'hA5, 0);
    rdsr(2, "R5 busy status all ones");
    rdmem(9'h1FE, 2, "R5 read refused while busy");
    settle();
    rdsr(1, "R10 enable cleared after cycle");
    rdmem(9'h1FE, 4, "R6 read wraps with A8");
    // R7: page limit
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h010, 10, 8'h80, 0);
    settle();
    rdmem(9'h010, 10, "R7 bytes past page discarded");
    // R7: partial byte blocks commit
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h020, 2, 8'h40, 4);
    rdsr(1, "R7 partial byte no commit");
    rdmem(9'h020, 2, "R7 partial byte no commit");
    // R9: status write takes bits 3:2 only
    cmd(8'h06, "R3 opcode echo");
    wrsr(8'hF8);
    settle();
    rdsr(1, "R9 only bp bits taken");
    // R8: upper half protected
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h0FF, 2, 8'h11, 0);
    settle();
    rdmem(9'h0FE, 3, "R8 upper half protected");
    // R8: upper quarter
    cmd(8'h06, "R3 opcode echo");
    wrsr(8'h04);
    settle();
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h17F, 2, 8'h33, 0);
    settle();
    rdmem(9'h17F, 2, "R8 upper quarter protected");
    // R8: whole array
    cmd(8'h06, "R3 opcode echo");
    wrsr(8'h0C);
    settle();
    cmd(8'h06, "R3 opcode echo");
    wrmem(9'h000, 1, 8'h55, 0);
    settle();
    rdmem(9'h000, 1, "R8 whole array protected");
    // R9: protection does not block status write
    cmd(8'h06, "R3 opcode echo");
    wrsr(8'h00);
    settle();
    rdsr(1, "R9 R4 status write back to zero");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      vecs++;
      $display("FAIL watchdog expired, got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule